// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a serial-peripheral master from the bus clock. Two division laws are offered and picked by a single law bit. The power-of-two law spaces serial clock edges by 2^N bus cycles, where N is a 4-bit exponent taken from the low bits of the divider code. The linear law spaces them by N+1 bus cycles, where N is the full 8-bit code. The fastest setting, power-of-two with N = 0, places an edge on every bus cycle.

The law bit, the divider code and the clock polarity are copied into shadow registers only on cycles where the controller enable is low. A running controller therefore never sees its divider move under it. The shift engine raises a run request for the length of a frame. While run and enable are both high, the block issues a one-cycle toggle strobe at every serial clock edge and flips its serial clock output at the same time. Whenever either input is low, the edge counter clears and the serial clock returns to the latched idle level, which is also driven out on its own port.

Top module: `sclk_divider`

## Requirements
- R1: While reset is asserted, `tick_o` is 0, `sclk_o` is 0 and `idle_level_o` is 0.
- R2: With law bit 0, `tick_o` pulses every 2^N bus cycles while running, where N = `div_code_i[3:0]`. Bits 7:4 of the code have no effect in this law.
- R3: With law bit 1, `tick_o` pulses every `div_code_i`+1 bus cycles while running (code 0 to 255, serial clock ratio 2*(code+1)).
- R4: With law bit 0 and N = 0, `tick_o` is high on every cycle of a run, so the serial clock toggles at every bus clock edge.
- R5: When `enable_i` or `run_i` is sampled low, the next cycle shows `tick_o` = 0 and `sclk_o` equal to the latched idle level.
- R6: Law bit, code and polarity are captured only at clock edges where `enable_i` is low. Changes while enabled alter neither tick spacing nor `idle_level_o`.
- R7: The edge counter restarts whenever run or enable is low. If run is first sampled high at edge k, the first tick is visible after edge k+H-1, where H is the half-period in bus cycles. Dropping run for one cycle restarts this count.
- R8: `sclk_o` changes level while running only in a cycle where `tick_o` is high, and it inverts in every such cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; configuration is latched while low |
| lin_mode_i | input | 1 | Division law: 0 power-of-two, 1 linear |
| div_code_i | input | 8 | Divider code |
| cpol_i | input | 1 | Clock polarity, the idle serial clock level |
| run_i | input | 1 | Run request from the shift engine |
| tick_o | output | 1 | One-cycle strobe at each serial clock edge |
| sclk_o | output | 1 | Serial clock level |
| idle_level_o | output | 1 | Latched idle level of the serial clock |

## Verification
The hardest case to reach from the ports is the slowest power-of-two setting. Here one half-period lasts 32768 bus cycles, and the counter must pass through its full 15-bit range before it wraps. The bench holds run high for that whole span and counts the cycles to the first strobe. Equally awkward is showing that configuration written during a run is ignored. The bench changes law, code and polarity in the middle of a run, measures the next strobe spacing and the idle level output, and then drops enable to show that the new values are only now taken.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    typedef enum logic {
        LAW_POW2 = 1'b0,
        LAW_LIN  = 1'b1
    } div_law_e;

endpackage

// File: rtl/sdiv_cfg_shadow.sv
module sdiv_cfg_shadow
    import sclkdiv_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              lin_mode_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              pol_i,
    output div_law_e          law_o,
    output logic [CODE_W-1:0] code_o,
    output logic              pol_o
);

    typedef struct packed {
        div_law_e          law;
        logic [CODE_W-1:0] code;
        logic              pol;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.law  = div_law_e'(lin_mode_i);
            st_d.code = code_i;
            st_d.pol  = pol_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{law: LAW_POW2, code: '0, pol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign law_o  = st_q.law;
    assign code_o = st_q.code;
    assign pol_o  = st_q.pol;

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(enable_i) |-> ($stable(st_q.law) && $stable(st_q.code) && $stable(st_q.pol))) // R6
        else $error("configuration moved while enabled");

endmodule

// File: rtl/sdiv_limit_decode.sv
module sdiv_limit_decode
    import sclkdiv_pkg::*;
#(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned EXP_W  = 4,
    parameter int unsigned CNT_W  = 15
) (
    input  div_law_e          law_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  limit_o
);

    logic [EXP_W-1:0] exp_w;
    logic [CNT_W-1:0] pow_limit_w;
    logic [CNT_W-1:0] lin_limit_w;

    assign exp_w = code_i[EXP_W-1:0];

    // 2^N - 1 as a thermometer: bit i is set when N exceeds i (no shifter)
    for (genvar i = 0; i < CNT_W; i++) begin : g_therm
        assign pow_limit_w[i] = (int'(exp_w) > i);
    end

    assign lin_limit_w = CNT_W'(code_i);

    always_comb begin
        unique case (law_i)
            LAW_LIN:  limit_o = lin_limit_w;
            default:  limit_o = pow_limit_w;
        endcase
    end

endmodule

// File: rtl/sdiv_edge_gen.sv
module sdiv_edge_gen #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             pol_i,
    output logic             tick_o,
    output logic             sclk_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
        logic             sclk;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!active_i) begin
            g_d.cnt  = '0;
            g_d.tick = 1'b0;
            g_d.sclk = pol_i;
        end else if (g_q.cnt == limit_i) begin
            g_d.cnt  = '0;
            g_d.tick = 1'b1;
            g_d.sclk = ~g_q.sclk;
        end else begin
            g_d.cnt  = g_q.cnt + CNT_W'(1);
            g_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            g_q <= '{cnt: '0, tick: 1'b0, sclk: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign tick_o = g_q.tick;
    assign sclk_o = g_q.sclk;

    AST_IDLE_HOLDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> (!tick_o && (sclk_o == $past(pol_i)))) // R5
        else $error("idle level not held");

    AST_TICK_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (sclk_o != $past(sclk_o))) // R8
        else $error("tick without level change");

    AST_STEADY_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(active_i) && !tick_o) |-> $stable(sclk_o)) // R8
        else $error("level moved without tick");

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_q.cnt <= limit_i) // R2
        else $error("counter beyond limit");

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> $past(active_i)) // R7
        else $error("tick while not running");

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclkdiv_pkg::*;
#(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned EXP_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              lin_mode_i,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic              cpol_i,
    input  logic              run_i,
    output logic              tick_o,
    output logic              sclk_o,
    output logic              idle_level_o
);

    localparam int unsigned POW_W = (1 << EXP_W) - 1;
    localparam int unsigned CNT_W = (POW_W > CODE_W) ? POW_W : CODE_W;

    div_law_e          law_w;
    logic [CODE_W-1:0] code_w;
    logic              pol_w;
    logic [CNT_W-1:0]  limit_w;
    logic              active_w;

    assign active_w = enable_i & run_i;

    sdiv_cfg_shadow #(.CODE_W(CODE_W)) i_shadow (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .lin_mode_i (lin_mode_i),
        .code_i     (div_code_i),
        .pol_i      (cpol_i),
        .law_o      (law_w),
        .code_o     (code_w),
        .pol_o      (pol_w)
    );

    sdiv_limit_decode #(.CODE_W(CODE_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) i_decode (
        .law_i   (law_w),
        .code_i  (code_w),
        .limit_o (limit_w)
    );

    sdiv_edge_gen #(.CNT_W(CNT_W)) i_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active_w),
        .limit_i  (limit_w),
        .pol_i    (pol_w),
        .tick_o   (tick_o),
        .sclk_o   (sclk_o)
    );

    assign idle_level_o = pol_w;

    AST_IDLE_OUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(enable_i) |-> $stable(idle_level_o)) // R6
        else $error("idle level changed while enabled");

endmodule

// File: tb/test_sclk_divider.sv
`timescale 1ns/1ps
module test_sclk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       lin = 1'b0;
    logic [7:0] code = 8'd0;
    logic       cpol = 1'b0;
    logic       run = 1'b0;
    logic       tick, sclk, idle_lvl;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sclk_divider i_sclk_divider (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .lin_mode_i   (lin),
        .div_code_i   (code),
        .cpol_i       (cpol),
        .run_i        (run),
        .tick_o       (tick),
        .sclk_o       (sclk),
        .idle_level_o (idle_lvl)
    );

    // behavioural reference
    int m_cnt, m_half, m_code;
    bit m_tick, m_sclk, m_pol, m_lin;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tick = 0; m_sclk = 0; m_pol = 0; m_lin = 0; m_code = 0;
        end else begin
            m_half = m_lin ? (m_code + 1) : (2 ** (m_code % 16));
            if (enable && run) begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= m_half) begin
                    m_cnt = 0; m_tick = 1; m_sclk = !m_sclk;
                end else begin
                    m_tick = 0;
                end
            end else begin
                m_cnt = 0; m_tick = 0; m_sclk = m_pol;
            end
            if (!enable) begin
                m_pol = cpol; m_lin = lin; m_code = int'(code);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tick == m_tick, "R8 model tick", int'(tick), int'(m_tick));
            chk(sclk == m_sclk, "R5 model sclk", int'(sclk), int'(m_sclk));
            chk(idle_lvl == m_pol, "R6 model idle level", int'(idle_lvl), int'(m_pol));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic count_to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick);
    endtask

    task automatic measure(input bit l, input logic [7:0] c, input bit p,
                           input int exp_h, input bit twice, input string tag);
        int n;
        @(negedge clk);
        enable = 0; run = 0; lin = l; code = c; cpol = p;
        @(negedge clk);
        @(negedge clk);
        chk(idle_lvl == p, "R6 idle level latched", int'(idle_lvl), int'(p));
        chk(sclk == p, "R5 idle sclk", int'(sclk), int'(p));
        enable = 1; run = 1;
        count_to_tick(n);
        chk(n == exp_h, {tag, " first edge"}, n, exp_h);
        if (twice) begin
            count_to_tick(n);
            chk(n == exp_h, {tag, " spacing"}, n, exp_h);
        end
        run = 0;
        @(negedge clk);
        chk(!tick && sclk == p, "R5 back to idle", int'(sclk), int'(p));
    endtask

    initial begin
        int n;
        @(negedge clk);
        chk(!tick && !sclk && !idle_lvl, "R1 reset state", int'({tick, sclk, idle_lvl}), 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        measure(1'b0, 8'h00, 1'b0, 1,   1'b1, "R4 pow2 N=0");
        measure(1'b0, 8'hF3, 1'b1, 8,   1'b1, "R2 pow2 upper bits ignored");
        measure(1'b0, 8'h02, 1'b0, 4,   1'b1, "R2 pow2 N=2");
        measure(1'b1, 8'h04, 1'b1, 5,   1'b1, "R3 linear code 4");
        measure(1'b1, 8'hFF, 1'b0, 256, 1'b1, "R3 linear code 255");
        measure(1'b1, 8'h00, 1'b0, 1,   1'b1, "R3 linear code 0");

        // R6: changes while enabled are ignored
        @(negedge clk);
        enable = 0; run = 0; lin = 1; code = 8'd3; cpol = 0;
        @(negedge clk);
        enable = 1; run = 1;
        lin = 0; code = 8'd0; cpol = 1;
        count_to_tick(n);
        chk(n == 4, "R6 first edge unaffected", n, 4);
        count_to_tick(n);
        chk(n == 4, "R6 spacing unaffected", n, 4);
        chk(idle_lvl == 0, "R6 idle level unaffected", int'(idle_lvl), 0);
        run = 0;
        @(negedge clk);
        chk(sclk == 0, "R5 old polarity kept", int'(sclk), 0);
        enable = 0;
        @(negedge clk);
        chk(idle_lvl == 1, "R6 latched once disabled", int'(idle_lvl), 1);

        // R5: enabled but no run produces no edges
        enable = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!tick && sclk == 1, "R5 enabled without run", int'(tick), 0);
        end

        // R7: restart on run drop
        enable = 0; lin = 1; code = 8'd9; cpol = 0;
        @(negedge clk);
        enable = 1; run = 1;
        for (int k = 0; k < 4; k++) @(negedge clk);
        run = 0;
        @(negedge clk);
        run = 1;
        count_to_tick(n);
        chk(n == 10, "R7 restart after run drop", n, 10);
        run = 0;
        @(negedge clk);

        measure(1'b0, 8'h0F, 1'b0, 32768, 1'b0, "R2 pow2 N=15");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule